// File: doc/BRIEF.md
# Interrupt Acknowledge Daisy-Chain Controller

This block keeps the interrupt state of a peripheral that has several prioritized request sources. Each source has a pending bit and an under-service bit. The block drives an active-low interrupt request. It also joins a priority chain of devices through an enable-in and an enable-out pin. When the host runs an acknowledge cycle, the block decides whether that cycle belongs to this device. If it does, the block latches the winning source as under service and returns an 8-bit vector on the data bus for the duration of that read.

The block treats all strobes as synchronous inputs on the peripheral clock. The acknowledge input is captured on each rising edge. A read is detected as a falling edge between two samples. Pending bits copy the source requests on a half-rate tick. That tick freezes while the register pointer selects one of two status registers, so new requests wait for it. A separate command clears the highest-priority under-service bit when the host finishes servicing.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset, `int_n` is 1, `data_oe` is 0, `data_out` is 0, no source is under service, and `ieo` follows `iei`.
- R2: Pending bits load `src_req` on a tick. The tick falls on every second clock that is not stalled. A raised request therefore pulls `int_n` low within four clocks.
- R3: While `reg_ptr` equals 2 or 3, the tick is stopped and the pending bits hold their value. Requests raised in that time reach `int_n` only after the pointer moves away.
- R4: An acknowledge is open in the clock after `intack_n` is sampled low. A read falling edge seen in that window claims the cycle only when `iei` is 1 and a request is active. The claim sets the under-service bit of the active source with the lowest index. Index 0 has the highest priority.
- R5: After a claim, `data_out` carries {`vec_hi`, 3-bit source index} and `data_oe` is 1. This starts in the clock after the claim edge and lasts while `rd_n` stays low and the acknowledge stays open. At all other times both are 0.
- R6: `int_n` is 0 exactly when some pending source has no under-service bit at its own or a higher priority. A claim therefore drives `int_n` to 1 in the next clock.
- R7: `ieo` is 1 only when `iei` is 1, no source is under service, and it is not the case that an acknowledge is open while a request is active.
- R8: Only the first read falling edge of an acknowledge counts. A later read in the same acknowledge sets no bit and drives no vector, even if it would qualify.
- R9: A `reset_ius` pulse clears the lowest-index under-service bit. If it coincides with a claim, it acts on the bits set before that edge, and the newly claimed bit survives.
- R10: A read falling edge while `iei` is 0 sets nothing and drives no vector.
- R11: A read falling edge while no acknowledge is open has no effect on the interrupt state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | NUM_SRC | Request level per source, bit 0 highest priority |
| reg_ptr | input | PTR_W | Current register pointer; two values stall the pending tick |
| vec_hi | input | VEC_W-SRC_W | Programmable upper field of the vector |
| intack_n | input | 1 | Interrupt acknowledge, active low |
| rd_n | input | 1 | Read strobe, active low |
| iei | input | 1 | Chain enable from the higher-priority neighbour |
| reset_ius | input | 1 | One-clock command that clears the highest under-service bit |
| int_n | output | 1 | Interrupt request, active low |
| ieo | output | 1 | Chain enable passed to the lower-priority neighbour |
| data_oe | output | 1 | Vector drive enable |
| data_out | output | VEC_W | Vector value, zero when not driven |

## Verification
Two functions can land on the same clock edge: the claim made by the first read of an acknowledge, and a `reset_ius` pulse that removes an older under-service bit. The bench provokes this by holding source 5 under service, raising source 0, and pulsing `reset_ius` in the same cycle that `rd_n` falls inside the acknowledge. The result is judged by what follows. `int_n` must stay high, because source 0 is now under service. A later pulse must then clear source 0 and let `int_n` fall again. A behavioural reference model is also compared against all outputs on every clock.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

   // Progress of one acknowledge window.
   typedef enum logic [1:0] {
      ACK_IDLE  = 2'd0,   // no acknowledge sampled
      ACK_OPEN  = 2'd1,   // acknowledge open, read not yet seen
      ACK_SERVE = 2'd2,   // read claimed the cycle, vector on the bus
      ACK_SPENT = 2'd3    // read consumed, nothing more until close
   } ack_state_e;

endpackage

// File: rtl/irq_rate_gen.sv
module irq_rate_gen #(
   parameter bit HALF_RATE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic stall,
   output logic tick
);

   generate
      if (HALF_RATE) begin : g_half
         logic phase_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      phase_q <= 1'b0;
            else if (!stall) phase_q <= ~phase_q;
         end
         assign tick = phase_q & ~stall;
      end else begin : g_full
         assign tick = ~stall;
      end
   endgenerate

endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
   parameter  int NUM_SRC = 6,
   localparam int SRC_W   = $clog2(NUM_SRC)
) (
   input  logic [NUM_SRC-1:0] pend,
   input  logic [NUM_SRC-1:0] ius,
   output logic               req_active,
   output logic [SRC_W-1:0]   cand_idx,
   output logic [NUM_SRC-1:0] ius_top
);

   logic [NUM_SRC-1:0] blocked;
   logic [NUM_SRC-1:0] open_req;

   // A source is blocked by any under-service bit at its own or higher priority.
   always_comb begin
      logic acc;
      acc = 1'b0;
      for (int i = 0; i < NUM_SRC; i++) begin
         acc        = acc | ius[i];
         blocked[i] = acc;
      end
   end

   assign open_req   = pend & ~blocked;
   assign req_active = |open_req;

   always_comb begin
      cand_idx = '0;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (open_req[i]) cand_idx = SRC_W'(i);
      end
   end

   // Lowest set under-service bit as a one-hot mask.
   assign ius_top = ius & (~ius + NUM_SRC'(1));

endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
   import irq_chain_pkg::*;
#(
   parameter  int NUM_SRC = 6,
   parameter  int VEC_W   = 8,
   localparam int SRC_W   = $clog2(NUM_SRC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   intack_n,
   input  logic                   rd_n,
   input  logic                   iei,
   input  logic                   req_active,
   input  logic [SRC_W-1:0]       cand_idx,
   input  logic [VEC_W-SRC_W-1:0] vec_hi,
   output logic                   ack_q,
   output logic                   claim,
   output logic                   data_oe,
   output logic [VEC_W-1:0]       data_out
);

   logic             rd_prev_q;
   ack_state_e       state_q, state_d;
   logic [VEC_W-1:0] vec_q;
   logic             rd_fall, window, consume;

   assign rd_fall = rd_prev_q & ~rd_n;
   assign window  = (state_q == ACK_IDLE) || (state_q == ACK_OPEN);
   assign consume = ack_q & rd_fall & window;
   assign claim   = consume & iei & req_active;

   always_comb begin
      state_d = state_q;
      if (!ack_q) begin
         state_d = ACK_IDLE;
      end else begin
         case (state_q)
            ACK_IDLE, ACK_OPEN: begin
               if (consume) state_d = claim ? ACK_SERVE : ACK_SPENT;
               else         state_d = ACK_OPEN;
            end
            ACK_SERVE: if (rd_n) state_d = ACK_SPENT;
            ACK_SPENT: state_d = ACK_SPENT;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q     <= 1'b0;
         rd_prev_q <= 1'b1;
         state_q   <= ACK_IDLE;
         vec_q     <= '0;
      end else begin
         ack_q     <= ~intack_n;
         rd_prev_q <= rd_n;
         state_q   <= state_d;
         if (claim) vec_q <= {vec_hi, cand_idx};
      end
   end

   assign data_oe  = ack_q & ~rd_n & (state_q == ACK_SERVE);
   assign data_out = data_oe ? vec_q : '0;

endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl #(
   parameter  int NUM_SRC   = 6,
   parameter  int VEC_W     = 8,
   parameter  int PTR_W     = 4,
   parameter  int STALL_LO  = 2,
   parameter  int STALL_HI  = 3,
   parameter  bit HALF_RATE = 1'b1,
   localparam int SRC_W     = $clog2(NUM_SRC)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NUM_SRC-1:0]     src_req,
   input  logic [PTR_W-1:0]       reg_ptr,
   input  logic [VEC_W-SRC_W-1:0] vec_hi,
   input  logic                   intack_n,
   input  logic                   rd_n,
   input  logic                   iei,
   input  logic                   reset_ius,
   output logic                   int_n,
   output logic                   ieo,
   output logic                   data_oe,
   output logic [VEC_W-1:0]       data_out
);

   generate
      if (NUM_SRC < 2) begin : g_bad_src
         $error("NUM_SRC must be at least 2");
      end
      if (SRC_W >= VEC_W) begin : g_bad_vec
         $error("vector too narrow for the source index");
      end
      if (STALL_LO >= 2**PTR_W || STALL_HI >= 2**PTR_W) begin : g_bad_ptr
         $error("stall pointer values exceed PTR_W");
      end
   endgenerate

   logic [NUM_SRC-1:0] ip_q, ius_q, ius_top, claim_mask;
   logic [SRC_W-1:0]   cand_idx;
   logic               stall, tick, req_active, ack_q, claim;

   assign stall = (reg_ptr == PTR_W'(STALL_LO)) || (reg_ptr == PTR_W'(STALL_HI));

   irq_rate_gen #(.HALF_RATE(HALF_RATE)) u_rate (
      .clk   (clk),
      .rst_n (rst_n),
      .stall (stall),
      .tick  (tick)
   );

   irq_prio_resolve #(.NUM_SRC(NUM_SRC)) u_prio (
      .pend       (ip_q),
      .ius        (ius_q),
      .req_active (req_active),
      .cand_idx   (cand_idx),
      .ius_top    (ius_top)
   );

   irq_ack_seq #(.NUM_SRC(NUM_SRC), .VEC_W(VEC_W)) u_ack (
      .clk        (clk),
      .rst_n      (rst_n),
      .intack_n   (intack_n),
      .rd_n       (rd_n),
      .iei        (iei),
      .req_active (req_active),
      .cand_idx   (cand_idx),
      .vec_hi     (vec_hi),
      .ack_q      (ack_q),
      .claim      (claim),
      .data_oe    (data_oe),
      .data_out   (data_out)
   );

   assign claim_mask = claim ? (NUM_SRC'(1) << cand_idx) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ip_q  <= '0;
         ius_q <= '0;
      end else begin
         if (tick) ip_q <= src_req;
         ius_q <= (ius_q & ~(reset_ius ? ius_top : '0)) | claim_mask;
      end
   end

   assign int_n = ~req_active;
   assign ieo   = iei & ~(|ius_q) & ~(ack_q & req_active);

endmodule

// File: rtl/irq_chain_ctrl_chk.sv
module irq_chain_ctrl_chk #(
   parameter int NUM_SRC = 6
) (
   input logic               clk,
   input logic               rst_n,
   input logic               iei,
   input logic               reset_ius,
   input logic               int_n,
   input logic               ieo,
   input logic               data_oe,
   input logic               ack_q,
   input logic               claim,
   input logic               stall,
   input logic [NUM_SRC-1:0] ip_q,
   input logic [NUM_SRC-1:0] ius_q
);

   AST_STALL_HOLDS_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      stall |=> (ip_q == $past(ip_q)));                                       // R3
   AST_ONE_SET_PER_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_q |=> ($countones(ius_q & ~$past(ius_q)) <= 1));                    // R4
   AST_VEC_AFTER_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_oe) |-> $past(claim));                                       // R5
   AST_CLAIM_RELEASES_INT: assert property (@(posedge clk) disable iff (!rst_n)
      claim |=> int_n);                                                       // R6
   AST_IUS_BLOCKS_IEO: assert property (@(posedge clk) disable iff (!rst_n)
      (|ius_q) |-> !ieo);                                                     // R7
   AST_RST_IUS_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      (reset_ius && !claim && (|ius_q)) |=>
         ($countones(ius_q) == $countones($past(ius_q)) - 1));               // R9
   AST_NO_SERVICE_WITHOUT_IEI: assert property (@(posedge clk) disable iff (!rst_n)
      !iei |=> ((ius_q & ~$past(ius_q)) == {NUM_SRC{1'b0}}));                // R10
   AST_NO_SET_OUTSIDE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_q |=> ((ius_q & ~$past(ius_q)) == {NUM_SRC{1'b0}}));              // R11

endmodule

bind irq_chain_ctrl irq_chain_ctrl_chk #(.NUM_SRC(NUM_SRC)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iei       (iei),
   .reset_ius (reset_ius),
   .int_n     (int_n),
   .ieo       (ieo),
   .data_oe   (data_oe),
   .ack_q     (ack_q),
   .claim     (claim),
   .stall     (stall),
   .ip_q      (ip_q),
   .ius_q     (ius_q)
);

// File: tb/irq_chain_ctrl_tb.sv
module irq_chain_ctrl_tb;

   localparam int NS = 6;

   logic          clk = 1'b0;
   logic          rst_n, intack_n, rd_n, iei, reset_ius;
   logic [NS-1:0] src_req;
   logic [3:0]    reg_ptr;
   logic [4:0]    vec_hi;
   logic          int_n, ieo, data_oe;
   logic [7:0]    data_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   bit model_on = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   irq_chain_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_ptr(reg_ptr),
      .vec_hi(vec_hi), .intack_n(intack_n), .rd_n(rd_n), .iei(iei),
      .reset_ius(reset_ius), .int_n(int_n), .ieo(ieo),
      .data_oe(data_oe), .data_out(data_out)
   );

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit [NS-1:0] m_ip, m_ius;
   bit          m_phase, m_ack, m_rdprev, m_used, m_serve;
   bit [7:0]    m_vec;

   function automatic int m_cand();
      bit blk;
      blk = 1'b0;
      for (int i = 0; i < NS; i++) begin
         blk = blk | m_ius[i];
         if (m_ip[i] && !blk) return i;
      end
      return -1;
   endfunction

   always @(posedge clk) begin
      int c;
      bit stl, tk, fall, cons, clm;
      if (!rst_n) begin
         m_ip = '0; m_ius = '0; m_phase = 0; m_ack = 0;
         m_rdprev = 1; m_used = 0; m_serve = 0; m_vec = '0;
      end else begin
         c    = m_cand();
         stl  = (reg_ptr == 4'd2) || (reg_ptr == 4'd3);
         tk   = m_phase && !stl;
         if (!stl) m_phase = !m_phase;
         fall = m_rdprev && !rd_n;
         cons = m_ack && fall && !m_used;
         clm  = cons && iei && (c >= 0);
         if (reset_ius) begin
            for (int i = 0; i < NS; i++) begin
               if (m_ius[i]) begin m_ius[i] = 1'b0; break; end
            end
         end
         if (clm) begin
            m_ius[c] = 1'b1;
            m_vec    = {vec_hi, 3'(c)};
         end
         if (tk) m_ip = src_req;
         if (!m_ack) begin
            m_used = 0; m_serve = 0;
         end else begin
            m_used = m_used | cons;
            if (clm)       m_serve = 1;
            else if (rd_n) m_serve = 0;
         end
         m_rdprev = rd_n;
         m_ack    = !intack_n;
      end
   end

   always @(negedge clk) begin
      int c;
      bit act, oe;
      if (model_on && !done) begin
         c   = m_cand();
         act = (c >= 0);
         oe  = m_ack && !rd_n && m_serve;
         chk("R6 model int_n", int_n, !act);
         chk("R7 model ieo", ieo, iei && (m_ius == '0) && !(m_ack && act));
         chk("R5 model data_oe", data_oe, oe);
         chk("R5 model data_out", data_out, oe ? m_vec : 8'h00);
      end
   end

   // ---------------- stimulus ----------------
   task automatic step(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic ack_cycle(bit two_reads, bit with_rst, logic exp_oe,
                            logic [7:0] exp_vec, string tag);
      intack_n = 1'b0;
      step(2);
      rd_n = 1'b0;
      reset_ius = with_rst;
      step(1);
      reset_ius = 1'b0;
      step(1);
      chk({tag, " data_oe"}, data_oe, exp_oe);
      chk({tag, " data_out"}, data_out, exp_vec);
      rd_n = 1'b1;
      step(1);
      if (two_reads) begin
         rd_n = 1'b0;
         step(2);
         chk("R8 second read oe", data_oe, 1'b0);
         rd_n = 1'b1;
         step(1);
      end
      intack_n = 1'b1;
      step(2);
   endtask

   task automatic pulse_rst_ius();
      reset_ius = 1'b1;
      step(1);
      reset_ius = 1'b0;
      step(1);
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      rst_n = 0; src_req = '0; reg_ptr = 4'd0; vec_hi = 5'b10101;
      intack_n = 1; rd_n = 1; iei = 1; reset_ius = 0;
      step(3);
      rst_n = 1;
      model_on = 1;
      step(1);
      chk("R1 int_n", int_n, 1'b1);
      chk("R1 ieo", ieo, 1'b1);
      chk("R1 data_oe", data_oe, 1'b0);
      chk("R1 data_out", data_out, 8'h00);

      src_req = 6'b000100;
      step(4);
      chk("R2 int_n after request", int_n, 1'b0);

      ack_cycle(0, 0, 1'b1, 8'hAA, "R4 claim src2");
      chk("R6 int_n released", int_n, 1'b1);
      chk("R7 ieo low under service", ieo, 1'b0);

      src_req = 6'b000101;
      step(4);
      chk("R6 higher source pierces", int_n, 1'b0);
      ack_cycle(1, 0, 1'b1, 8'hA8, "R4 claim src0");
      chk("R6 int_n after nested claim", int_n, 1'b1);

      pulse_rst_ius();
      chk("R9 top bit cleared", int_n, 1'b0);
      pulse_rst_ius();
      chk("R9 all cleared ieo", ieo, 1'b1);

      // first read with iei low, second read with iei high
      intack_n = 0;
      step(2);
      iei = 0; rd_n = 0;
      step(2);
      chk("R10 no vector with iei low", data_oe, 1'b0);
      rd_n = 1; iei = 1;
      step(1);
      rd_n = 0;
      step(2);
      chk("R8 late read ignored", data_oe, 1'b0);
      rd_n = 1;
      step(1);
      intack_n = 1;
      step(2);
      chk("R8 nothing under service", int_n, 1'b0);

      rd_n = 0;
      step(2);
      rd_n = 1;
      step(2);
      chk("R11 int_n after bare read", int_n, 1'b0);
      chk("R11 ieo after bare read", ieo, 1'b1);

      src_req = '0;
      step(4);
      chk("R2 request withdrawn", int_n, 1'b1);
      reg_ptr = 4'd2; src_req = 6'b100000;
      step(6);
      chk("R3 stalled at 2", int_n, 1'b1);
      reg_ptr = 4'd3;
      step(4);
      chk("R3 stalled at 3", int_n, 1'b1);
      reg_ptr = 4'd7;
      step(4);
      chk("R3 released", int_n, 1'b0);

      iei = 0;
      ack_cycle(0, 0, 1'b0, 8'h00, "R10 iei low");
      chk("R10 still requesting", int_n, 1'b0);
      iei = 1;

      ack_cycle(0, 0, 1'b1, 8'hAD, "R4 claim src5");
      src_req = 6'b100011;
      step(4);
      chk("R6 src0 pierces src5", int_n, 1'b0);
      ack_cycle(0, 1, 1'b1, 8'hA8, "R9 claim with reset");
      chk("R9 new bit survives", int_n, 1'b1);
      pulse_rst_ius();
      chk("R9 src0 cleared", int_n, 1'b0);
      chk("R7 ieo outside ack", ieo, 1'b1);

      step(2);
      done = 1;
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog all requirements actual=running expected=finished");
         done = 1;
         report();
         $finish;
      end
   end

endmodule